// File: doc/BRIEF.md
# Interrupt Priority Arbitration Core

This block is the vector-tracking heart of a per-processor interrupt controller. It keeps three 256-bit maps: vectors that have been requested, vectors currently being serviced, and the trigger kind last recorded for each vector. From these maps and a task priority register it derives a processor priority value. It raises an interrupt-pending line whenever the best waiting request belongs to a priority class above that value.

A processor acknowledge moves the winning vector from the request map to the in-service map and reports it on the following cycle. If the best request is held back by priority, the acknowledge reports the configured spurious vector instead and changes no map. An end-of-interrupt retires the highest in-service vector. When that vector was recorded as level-triggered and directed end-of-interrupt is off, the block emits a one-cycle broadcast strobe carrying the vector, so that upstream level sources can re-arm.

Register-bus decoding, the timer and delivery to other units live outside this block. The block sees only strobes and write data.

Top module: `intr_prio_core`

## Requirements
- R1: After reset all three maps are empty, the task priority is 0 and the spurious register holds vector 0xFF with bit 8 (enable) and bit 12 (directed EOI) clear. Therefore irq_pending, ppr, ack_valid and eoi_bcast are all 0.
- R2: The winning request is the highest-numbered set bit of the request map, searched across all 32-bit words.
- R3: ppr equals the full 8-bit task priority when the task priority's class (bits 7:4) is at least the class of the highest in-service vector. Otherwise ppr is that in-service class in bits 7:4 with bits 3:0 zero. An empty in-service map counts as class 0.
- R4: A request is pending only when its class is strictly greater than the class of ppr, except that any request is pending when ppr is 0.
- R5: While spurious bit 8 is clear, irq_pending is 0 and an acknowledge returns nothing (ack_valid stays 0) and changes no map.
- R6: An acknowledge while the best request is blocked by priority returns ack_valid=1, ack_spur=1 and ack_vec equal to spurious bits 7:0. The request and in-service maps are left unchanged.
- R7: A successful acknowledge clears the vector's request bit and sets its in-service bit. ack_valid=1, ack_spur=0 and ack_vec are presented in the cycle after ack_req.
- R8: A set request sets the vector's request bit and records its trigger kind: set_level=1 marks it level, 0 marks it edge.
- R9: An end-of-interrupt clears the highest in-service bit. In the next cycle eoi_bcast pulses with that vector only when it was recorded level and spurious bit 12 is clear.
- R10: An end-of-interrupt with an empty in-service map changes nothing and emits no broadcast.
- R11: A 4-bit priority write stores the value in bits 7:4 of the task priority with bits 3:0 zero. A byte write stores the byte as given, and the byte write wins when both occur in one cycle.
- R12: A spurious register write keeps bits 7:0 (vector), bit 8 (enable) and bit 12 (directed EOI) of the write data and discards every other bit.
- R13: irq_pending and ppr are combinational functions of the current maps, task priority and enable. They reflect a register update in the same cycle that the update is registered.
- R14: A set request and an acknowledge of the same vector in one cycle leave the request bit set, while the vector still enters service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_req | input | 1 | Record a request for set_vec |
| set_vec | input | 8 | Vector to request |
| set_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| ack_req | input | 1 | Processor acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| tpr_nib_we | input | 1 | 4-bit priority write enable |
| tpr_nib | input | 4 | 4-bit priority class value |
| tpr_byte_we | input | 1 | Full task priority write enable |
| tpr_byte | input | 8 | Full task priority value |
| spur_we | input | 1 | Spurious register write enable |
| spur_wdata | input | 32 | Spurious register write data |
| irq_pending | output | 1 | A request beats the processor priority |
| ppr | output | 8 | Processor priority |
| ack_valid | output | 1 | Acknowledge result valid (one cycle after ack_req) |
| ack_spur | output | 1 | Acknowledge result is the spurious vector |
| ack_vec | output | 8 | Acknowledged vector |
| eoi_bcast | output | 1 | End-of-interrupt broadcast strobe |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |

## Verification
The arbitration is driven with requests spread over several 32-bit words, including two in the same word. This separates a true top-down search from a per-word or lowest-first pick. The task priority is placed just below, equal to and above the class of the waiting request, and the processor priority is held at exactly zero with a class-0 vector. These settings separate strict from non-strict class comparison and show the zero-priority exception. End-of-interrupt is tried on level and edge vectors, with directed EOI on and off, and on an empty service map. A same-cycle set and acknowledge of one vector shows which of the two map updates wins.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;
  localparam int VEC_W        = 8;
  localparam int CLS_W        = 4;
  localparam int SUB_W        = VEC_W - CLS_W;
  localparam int NUM_VEC      = 1 << VEC_W;
  localparam int SPUR_EN_BIT  = 8;
  localparam int SPUR_DIR_BIT = 12;

  // priority class of a vector: its upper bits
  function automatic logic [CLS_W-1:0] vec_class(input logic [VEC_W-1:0] v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  // processor priority from task priority and in-service class
  function automatic logic [VEC_W-1:0] proc_prio(input logic [VEC_W-1:0] tpr,
                                                 input logic [CLS_W-1:0] isr_cls);
    if (vec_class(tpr) >= isr_cls) return tpr;
    return {isr_cls, {SUB_W{1'b0}}};
  endfunction

  // does a request beat the processor priority
  function automatic logic beats(input logic [VEC_W-1:0] req,
                                 input logic [VEC_W-1:0] pp);
    return (pp == '0) || (vec_class(req) > vec_class(pp));
  endfunction
endpackage

// File: rtl/intr_vec_scan.sv
module intr_vec_scan #(
  parameter int NUM_VEC   = 256,
  parameter int SCAN_WORD = 32,
  localparam int IDX_W    = $clog2(NUM_VEC),
  localparam int NWORDS   = NUM_VEC / SCAN_WORD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] bits,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  logic [NWORDS-1:0] word_nz;

  genvar w;
  generate
    for (w = 0; w < NWORDS; w++) begin : g_word
      assign word_nz[w] = |bits[w*SCAN_WORD +: SCAN_WORD];
    end
  endgenerate

  // top word wins; inside a word the top bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int wi = 0; wi < NWORDS; wi++) begin
      if (word_nz[wi]) begin
        found = 1'b1;
        for (int b = 0; b < SCAN_WORD; b++) begin
          if (bits[wi*SCAN_WORD + b]) idx = IDX_W'(wi*SCAN_WORD + b);
        end
      end
    end
  end

  // R2
  scan_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> bits[idx]);
  // R2
  scan_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (bits == '0));
endmodule

// File: rtl/intr_vec_maps.sv
module intr_vec_maps #(
  parameter int NUM_VEC = 256,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               set_level,
  input  logic               take_en,
  input  logic [IDX_W-1:0]   take_idx,
  input  logic               retire_en,
  input  logic [IDX_W-1:0]   retire_idx,
  output logic [NUM_VEC-1:0] irr_q,
  output logic [NUM_VEC-1:0] isr_q,
  output logic [NUM_VEC-1:0] tmr_q
);
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (take_en)   irr_d[take_idx]   = 1'b0;
    if (set_en)    irr_d[set_idx]    = 1'b1;   // set wins over take
    if (retire_en) isr_d[retire_idx] = 1'b0;
    if (take_en)   isr_d[take_idx]   = 1'b1;
    if (set_en)    tmr_d[set_idx]    = set_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
    end
  end

  // R7
  take_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_en && !(set_en && set_idx == take_idx))
      |=> (!irr_q[$past(take_idx)] && isr_q[$past(take_idx)]));
  // R14
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> irr_q[$past(set_idx)]);
  // R8
  tmr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (tmr_q[$past(set_idx)] == $past(set_level)));
  // R9
  retire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_en && !(take_en && take_idx == retire_idx)) |=> !isr_q[$past(retire_idx)]);
endmodule

// File: rtl/intr_prio_calc.sv
module intr_prio_calc
  import intr_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             irr_found,
  input  logic [VEC_W-1:0] irr_top,
  input  logic             isr_found,
  input  logic [VEC_W-1:0] isr_top,
  input  logic [VEC_W-1:0] tpr,
  output logic [VEC_W-1:0] ppr,
  output logic             pending,
  output logic             blocked
);
  logic [CLS_W-1:0] isr_cls;
  logic             wins;

  assign isr_cls = isr_found ? vec_class(isr_top) : '0;
  assign ppr     = proc_prio(tpr, isr_cls);
  assign wins    = irr_found && beats(irr_top, ppr);
  assign pending = enable && wins;
  assign blocked = enable && irr_found && !wins;

  // R3
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_class(ppr) >= isr_cls) && (vec_class(ppr) >= vec_class(tpr)));
  // R4
  strict_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && ppr != '0) |-> (vec_class(irr_top) > vec_class(ppr)));
  // R5
  pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!pending && !blocked));
  // R6
  pend_block_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending && blocked));
endmodule

// File: rtl/intr_prio_core.sv
module intr_prio_core
  import intr_prio_pkg::*;
#(
  parameter int SCAN_WORD = 32,
  parameter int REG_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             set_level,
  input  logic             ack_req,
  input  logic             eoi_req,
  input  logic             tpr_nib_we,
  input  logic [CLS_W-1:0] tpr_nib,
  input  logic             tpr_byte_we,
  input  logic [VEC_W-1:0] tpr_byte,
  input  logic             spur_we,
  input  logic [REG_W-1:0] spur_wdata,
  output logic             irq_pending,
  output logic [VEC_W-1:0] ppr,
  output logic             ack_valid,
  output logic             ack_spur,
  output logic [VEC_W-1:0] ack_vec,
  output logic             eoi_bcast,
  output logic [VEC_W-1:0] eoi_bcast_vec
);
  // configuration registers
  logic [VEC_W-1:0] tpr_q;
  logic [VEC_W-1:0] spur_vec_q;
  logic             spur_en_q;
  logic             spur_dir_q;

  // maps and search results
  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic               irr_found, isr_found;
  logic [VEC_W-1:0]   irr_top, isr_top;
  logic               pend, blocked;

  // named internal events
  logic ack_take, ack_block, eoi_do, bcast_hit;

  assign ack_take  = ack_req && pend;
  assign ack_block = ack_req && blocked;
  assign eoi_do    = eoi_req && isr_found;
  assign bcast_hit = eoi_do && tmr[isr_top] && !spur_dir_q;

  wire unused_spur_bits = ^{spur_wdata[REG_W-1:SPUR_DIR_BIT+1],
                            spur_wdata[SPUR_DIR_BIT-1:SPUR_EN_BIT+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q      <= '0;
      spur_vec_q <= '1;
      spur_en_q  <= 1'b0;
      spur_dir_q <= 1'b0;
    end else begin
      if (tpr_byte_we)     tpr_q <= tpr_byte;
      else if (tpr_nib_we) tpr_q <= {tpr_nib, {SUB_W{1'b0}}};
      if (spur_we) begin
        spur_vec_q <= spur_wdata[VEC_W-1:0];
        spur_en_q  <= spur_wdata[SPUR_EN_BIT];
        spur_dir_q <= spur_wdata[SPUR_DIR_BIT];
      end
    end
  end

  intr_vec_maps #(.NUM_VEC(NUM_VEC)) u_maps (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (set_req),
    .set_idx    (set_vec),
    .set_level  (set_level),
    .take_en    (ack_take),
    .take_idx   (irr_top),
    .retire_en  (eoi_do),
    .retire_idx (isr_top),
    .irr_q      (irr),
    .isr_q      (isr),
    .tmr_q      (tmr)
  );

  intr_vec_scan #(.NUM_VEC(NUM_VEC), .SCAN_WORD(SCAN_WORD)) u_irr_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .bits  (irr),
    .found (irr_found),
    .idx   (irr_top)
  );

  intr_vec_scan #(.NUM_VEC(NUM_VEC), .SCAN_WORD(SCAN_WORD)) u_isr_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .bits  (isr),
    .found (isr_found),
    .idx   (isr_top)
  );

  intr_prio_calc u_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (spur_en_q),
    .irr_found (irr_found),
    .irr_top   (irr_top),
    .isr_found (isr_found),
    .isr_top   (isr_top),
    .tpr       (tpr_q),
    .ppr       (ppr),
    .pending   (pend),
    .blocked   (blocked)
  );

  assign irq_pending = pend;

  // registered acknowledge and broadcast results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid     <= 1'b0;
      ack_spur      <= 1'b0;
      ack_vec       <= '0;
      eoi_bcast     <= 1'b0;
      eoi_bcast_vec <= '0;
    end else begin
      ack_valid <= ack_take || ack_block;
      ack_spur  <= ack_block;
      if (ack_take)       ack_vec <= irr_top;
      else if (ack_block) ack_vec <= spur_vec_q;
      eoi_bcast <= bcast_hit;
      if (bcast_hit) eoi_bcast_vec <= isr_top;
    end
  end

  // R6
  spur_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_block |=> (ack_valid && ack_spur && ack_vec == $past(spur_vec_q)));
  // R5
  ack_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !spur_en_q) |=> !ack_valid);
  // R10
  eoi_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && !isr_found) |=> !eoi_bcast);
  // R9
  bcast_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast |-> ($past(eoi_req) && !$past(spur_dir_q)));
endmodule

// File: tb/intr_prio_core_tb.sv
`timescale 1ns/1ps
module intr_prio_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       set_req = 1'b0, set_level = 1'b0, ack_req = 1'b0, eoi_req = 1'b0;
  logic [7:0] set_vec = '0, tpr_byte = '0;
  logic       tpr_nib_we = 1'b0, tpr_byte_we = 1'b0, spur_we = 1'b0;
  logic [3:0] tpr_nib = '0;
  logic [31:0] spur_wdata = '0;
  logic       irq_pending, ack_valid, ack_spur, eoi_bcast;
  logic [7:0] ppr, ack_vec, eoi_bcast_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intr_prio_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .set_req(set_req), .set_vec(set_vec), .set_level(set_level),
    .ack_req(ack_req), .eoi_req(eoi_req),
    .tpr_nib_we(tpr_nib_we), .tpr_nib(tpr_nib),
    .tpr_byte_we(tpr_byte_we), .tpr_byte(tpr_byte),
    .spur_we(spur_we), .spur_wdata(spur_wdata),
    .irq_pending(irq_pending), .ppr(ppr),
    .ack_valid(ack_valid), .ack_spur(ack_spur), .ack_vec(ack_vec),
    .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_set(input logic [7:0] v, input logic lvl);
    set_req = 1'b1; set_vec = v; set_level = lvl;
    step();
    set_req = 1'b0;
  endtask

  task automatic do_ack();
    ack_req = 1'b1;
    step();
    ack_req = 1'b0;
  endtask

  task automatic do_eoi();
    eoi_req = 1'b1;
    step();
    eoi_req = 1'b0;
  endtask

  task automatic wr_spur(input logic [31:0] d);
    spur_we = 1'b1; spur_wdata = d;
    step();
    spur_we = 1'b0;
  endtask

  task automatic wr_tpr(input logic nib_we, input logic [3:0] nib,
                        input logic byte_we, input logic [7:0] b);
    tpr_nib_we = nib_we; tpr_nib = nib; tpr_byte_we = byte_we; tpr_byte = b;
    step();
    tpr_nib_we = 1'b0; tpr_byte_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pending", irq_pending, 0);
    chk("R1 ppr", ppr, 8'h00);
    chk("R1 ack_valid", ack_valid, 0);
    chk("R1 eoi_bcast", eoi_bcast, 0);
  endtask

  task automatic t_disabled();
    do_set(8'h40, 1'b0);
    chk("R5 pending while disabled", irq_pending, 0);
    do_ack();
    chk("R5 ack_valid while disabled", ack_valid, 0);
    chk("R5 ppr unchanged", ppr, 8'h00);
    wr_spur(32'hFFFF_E1FF);           // vector FF, enable on, directed off
    chk("R13 pending same cycle as enable", irq_pending, 1);
  endtask

  task automatic t_ack_basic();
    do_ack();
    chk("R7 ack_valid", ack_valid, 1);
    chk("R7 ack_spur", ack_spur, 0);
    chk("R7 ack_vec", ack_vec, 8'h40);
    chk("R7 irr cleared", irq_pending, 0);
    chk("R3 ppr from isr class", ppr, 8'h40);
  endtask

  task automatic t_scan();
    do_set(8'h21, 1'b0);
    do_set(8'h9F, 1'b1);
    do_set(8'h85, 1'b0);
    chk("R8 pending after set", irq_pending, 1);
    do_ack();
    chk("R2 top vector", ack_vec, 8'h9F);
    chk("R3 ppr class 9", ppr, 8'h90);
    chk("R4 lower class blocked", irq_pending, 0);
    do_ack();
    chk("R6 ack_valid", ack_valid, 1);
    chk("R6 ack_spur", ack_spur, 1);
    chk("R6 spurious vec", ack_vec, 8'hFF);
    chk("R6 isr unchanged", ppr, 8'h90);
  endtask

  task automatic t_eoi();
    do_eoi();
    chk("R9 bcast level", eoi_bcast, 1);
    chk("R9 bcast vec", eoi_bcast_vec, 8'h9F);
    chk("R9 isr top cleared", ppr, 8'h40);
    chk("R6 irr kept after spurious", irq_pending, 1);
    do_ack();
    chk("R2 next vector", ack_vec, 8'h85);
    do_eoi();
    chk("R8 edge vector no bcast", eoi_bcast, 0);
    chk("R9 ppr after edge eoi", ppr, 8'h40);
    do_eoi();
    chk("R9 ppr empty isr", ppr, 8'h00);
  endtask

  task automatic t_empty_eoi();
    do_eoi();
    chk("R10 no bcast", eoi_bcast, 0);
    chk("R10 ppr", ppr, 8'h00);
    chk("R10 pending kept", irq_pending, 1);
  endtask

  task automatic t_tpr();
    wr_tpr(1'b1, 4'h3, 1'b0, 8'h00);
    chk("R11 nibble write", ppr, 8'h30);
    chk("R4 class below tpr", irq_pending, 0);
    wr_tpr(1'b0, 4'h0, 1'b1, 8'h25);
    chk("R11 byte write", ppr, 8'h25);
    chk("R4 equal class not pending", irq_pending, 0);
    wr_tpr(1'b0, 4'h0, 1'b1, 8'h1F);
    chk("R4 higher class pending", irq_pending, 1);
    wr_tpr(1'b1, 4'h7, 1'b1, 8'h12);
    chk("R11 byte write wins", ppr, 8'h12);
    wr_tpr(1'b0, 4'h0, 1'b1, 8'h00);
    chk("R11 cleared", ppr, 8'h00);
  endtask

  task automatic t_zero_ppr();
    do_ack();
    chk("R7 ack 21", ack_vec, 8'h21);
    do_eoi();
    do_set(8'h05, 1'b0);
    chk("R4 zero ppr exception", irq_pending, 1);
    wr_tpr(1'b0, 4'h0, 1'b1, 8'h01);
    chk("R4 class 0 vs ppr 01", irq_pending, 0);
    wr_tpr(1'b0, 4'h0, 1'b1, 8'h00);
    do_ack();
    chk("R4 class 0 acked", ack_vec, 8'h05);
    do_eoi();
  endtask

  task automatic t_collide();
    do_set(8'h60, 1'b0);
    set_req = 1'b1; set_vec = 8'h60; set_level = 1'b0; ack_req = 1'b1;
    step();
    set_req = 1'b0; ack_req = 1'b0;
    chk("R14 ack vec", ack_vec, 8'h60);
    chk("R14 in service", ppr, 8'h60);
    do_ack();
    chk("R14 irr kept -> spurious", ack_spur, 1);
    do_eoi();
    chk("R14 no bcast", eoi_bcast, 0);
    chk("R14 still pending", irq_pending, 1);
  endtask

  task automatic t_spur_fields();
    wr_spur(32'h0000_1123);           // vector 23, enable on, directed on
    do_set(8'h70, 1'b1);
    do_ack();
    chk("R2 ack 70", ack_vec, 8'h70);
    do_ack();
    chk("R12 spurious vector field", ack_vec, 8'h23);
    do_eoi();
    chk("R12 directed eoi suppresses bcast", eoi_bcast, 0);
    chk("R9 ppr after eoi", ppr, 8'h00);
    wr_spur(32'hFFFF_E0AB);           // enable off
    chk("R12 enable bit cleared", irq_pending, 0);
    do_ack();
    chk("R5 no ack when disabled", ack_valid, 0);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_disabled();
    t_ack_basic();
    t_scan();
    t_eoi();
    t_empty_eoi();
    t_tpr();
    t_zero_ppr();
    t_collide();
    t_spur_fields();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule